// File: doc/BRIEF.md
# Line oscillator calibration controller

This block is the digital control side of a horizontal line timebase. It holds the frequency-control code of a digitally tuned oscillator. It divides the oscillator tick stream by 432 to make the line-rate pulse that feeds the phase loop. When the oscillator runs at the nominal 6.75 MHz, 432 ticks span one line period. The controller also calibrates the oscillator. It counts oscillator ticks over a window made of reference ticks taken from the active crystal, and it lowers the code one step at a time until the count no longer exceeds the target.

After reset the code sits at a safe value that keeps the oscillator above nominal. Calibration can start only once the crystal indication has been written (subaddress 0x00) and the control register (subaddress 0x01) is written after it. A control write that comes first does not start anything. Once the block is calibrated, a loss-of-lock indication reloads the safe code and runs the calibration again. The control register also holds a loop-open bit and the loop time-constant mode. In automatic mode the time constant follows the lock and noise inputs.

Top module: `line_cal_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `freq_code` equals the safe code (default 200), `calibrating`, `cal_done`, `meas_valid`, `line_pulse` and `loop_open` are 0, `xtal_sel` is 0, and `tc_sel` gives the automatic-mode result for its inputs.
- R2: Until the first calibration has started, `freq_code` stays at the safe code.
- R3: A write to subaddress 0x00 stores `wr_data[1:0]` in `xtal_sel` in the following cycle.
- R4: A write to subaddress 0x01 starts a calibration (`calibrating` goes high after that clock edge) only if a subaddress 0x00 write has been seen since reset. A 0x01 write before that leaves `calibrating` low and the code at the safe value.
- R5: During calibration, each window spans WIN reference ticks (default 256) and counts the oscillator ticks in it. The first window after every code load or code change is discarded. Every other window pulses `meas_valid` with the count on `meas_count`. If the count is above TARGET (default 180), `freq_code` drops by exactly one in that same cycle and never rises during calibration.
- R6: A reported count at or below TARGET ends the calibration in that cycle: `calibrating` falls, `cal_done` rises and the code is held.
- R7: When `cal_done` is high, a one-cycle `out_of_lock` reloads the safe code and restarts calibration. While `calibrating` is high, `out_of_lock` is ignored: the code is not reloaded.
- R8: A subaddress 0x01 write while `cal_done` is high does not restart calibration.
- R9: `line_pulse` is a single-cycle pulse that comes once for every 432 oscillator ticks.
- R10: `loop_open` follows bit 0 of the last subaddress 0x01 write.
- R11: The time-constant mode is `wr_data[2:1]` of a 0x01 write: 01 forces fast, 10 forces slow, and 00 or 11 mean automatic. In automatic mode the result is slow when `phase_locked`=1 and `noise_flag`=0, and medium otherwise. `tc_sel` encodes slow=0, medium=1 and fast=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| ref_tick | input | 1 | One-cycle pulse per crystal-derived reference period |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | 8 | Decoded register subaddress |
| wr_data | input | 3 | Register write data |
| out_of_lock | input | 1 | Loss-of-lock indication from the coincidence detector |
| phase_locked | input | 1 | Phase loop lock state |
| noise_flag | input | 1 | Noisy input signal indication |
| freq_code | output | 8 | Oscillator frequency-control code |
| line_pulse | output | 1 | Line-rate pulse, oscillator divided by 432 |
| calibrating | output | 1 | Calibration in progress |
| cal_done | output | 1 | Oscillator calibrated, normal running |
| meas_valid | output | 1 | One-cycle strobe with a new window count |
| meas_count | output | 16 | Oscillator ticks counted in the last reported window |
| xtal_sel | output | 2 | Stored crystal indication bits |
| loop_open | output | 1 | Phase loop opened by register |
| tc_sel | output | 2 | Selected loop time constant |

## Verification
Suppose the sequencing state is wrong, for example a start accepted before the crystal write. Then `calibrating` rises, or stays low, right after the offending write, so the fault shows within one clock. A wrong settle flag or a wrong window length shows as a reported count that differs from the code the oscillator model was running. That mismatch appears at the first `meas_valid`, about two windows after the start. A divider fault shows as a line period other than 432 ticks at the next line pulse.

// File: rtl/line_cal_pkg.sv
package line_cal_pkg;

    localparam int unsigned REG_ADDR_W = 8;
    localparam int unsigned REG_DATA_W = 3;

    localparam logic [REG_ADDR_W-1:0] SUB_XTAL = 8'h00;
    localparam logic [REG_ADDR_W-1:0] SUB_CTRL = 8'h01;

    typedef enum logic [1:0] {
        ST_WAIT_XTAL  = 2'd0,
        ST_WAIT_START = 2'd1,
        ST_CAL        = 2'd2,
        ST_RUN        = 2'd3
    } cal_state_t;

    typedef enum logic [1:0] {
        TC_SLOW   = 2'd0,
        TC_MEDIUM = 2'd1,
        TC_FAST   = 2'd2
    } tc_t;

    typedef enum logic [1:0] {
        MODE_AUTO      = 2'd0,
        MODE_FAST      = 2'd1,
        MODE_SLOW      = 2'd2,
        MODE_AUTO_ALT  = 2'd3
    } tc_mode_t;

    typedef struct packed {
        tc_mode_t mode;
        logic     open;
    } ctrl_reg_t;

    function automatic tc_t pick_tc(tc_mode_t m, logic locked, logic noisy);
        tc_t r;
        case (m)
            MODE_FAST: r = TC_FAST;
            MODE_SLOW: r = TC_SLOW;
            default:   r = (locked && !noisy) ? TC_SLOW : TC_MEDIUM;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcc_regs.sv
module lcc_regs
    import line_cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_stb,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [REG_DATA_W-1:0] wr_data,
    input  logic                  phase_locked,
    input  logic                  noise_flag,
    output logic                  wr_xtal,
    output logic                  wr_ctrl,
    output logic [1:0]            xtal_q,
    output ctrl_reg_t             ctrl_q,
    output tc_t                   tc_q
);
    assign wr_xtal = wr_stb && (wr_addr == SUB_XTAL);
    assign wr_ctrl = wr_stb && (wr_addr == SUB_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            xtal_q <= '0;
            ctrl_q <= '{mode: MODE_AUTO, open: 1'b0};
        end else begin
            if (wr_xtal) xtal_q <= wr_data[1:0];
            if (wr_ctrl) ctrl_q <= '{mode: tc_mode_t'(wr_data[2:1]), open: wr_data[0]};
        end
    end

    assign tc_q = pick_tc(ctrl_q.mode, phase_locked, noise_flag);

endmodule

// File: rtl/lcc_meas.sv
module lcc_meas #(
    parameter int unsigned WIN   = 256,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             osc_tick,
    input  logic             ref_tick,
    output logic             win_end,
    output logic [CNT_W-1:0] win_count
);
    localparam int unsigned REF_W = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(WIN - 1);

    logic [REF_W-1:0] ref_cnt;
    logic [CNT_W-1:0] osc_cnt;

    assign win_count = (osc_tick && (osc_cnt != '1)) ? osc_cnt + CNT_W'(1) : osc_cnt;
    assign win_end   = run && ref_tick && (ref_cnt == REF_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ref_cnt <= '0;
            osc_cnt <= '0;
        end else begin
            if (ref_tick) ref_cnt <= win_end ? '0 : ref_cnt + REF_W'(1);
            osc_cnt <= win_end ? '0 : win_count;
        end
    end

endmodule

// File: rtl/lcc_divider.sv
module lcc_divider #(
    parameter int unsigned DIV = 432
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    output logic line_pulse
);
    localparam int unsigned DW = $clog2(DIV);
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    logic [DW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt    <= '0;
            line_pulse <= 1'b0;
        end else begin
            line_pulse <= osc_tick && (div_cnt == DIV_LAST);
            if (osc_tick) div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + DW'(1);
        end
    end

endmodule

// File: rtl/line_cal_ctrl.sv
module line_cal_ctrl
    import line_cal_pkg::*;
#(
    parameter int unsigned CODE_W    = 8,
    parameter int unsigned CODE_SAFE = 200,
    parameter int unsigned TARGET    = 180,
    parameter int unsigned WIN       = 256,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned DIV       = 432
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              ref_tick,
    input  logic              wr_stb,
    input  logic [7:0]        wr_addr,
    input  logic [2:0]        wr_data,
    input  logic              out_of_lock,
    input  logic              phase_locked,
    input  logic              noise_flag,
    output logic [CODE_W-1:0] freq_code,
    output logic              line_pulse,
    output logic              calibrating,
    output logic              cal_done,
    output logic              meas_valid,
    output logic [CNT_W-1:0]  meas_count,
    output logic [1:0]        xtal_sel,
    output logic              loop_open,
    output logic [1:0]        tc_sel
);
    localparam logic [CODE_W-1:0] SAFE_CODE = CODE_W'(CODE_SAFE);
    localparam logic [CNT_W-1:0]  TGT_CNT   = CNT_W'(TARGET);

    cal_state_t       state;
    logic             settle;
    logic             wr_xtal, wr_ctrl;
    ctrl_reg_t        ctrl_q;
    tc_t              tc_q;
    logic             win_end;
    logic [CNT_W-1:0] win_count;

    lcc_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_stb       (wr_stb),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .phase_locked (phase_locked),
        .noise_flag   (noise_flag),
        .wr_xtal      (wr_xtal),
        .wr_ctrl      (wr_ctrl),
        .xtal_q       (xtal_sel),
        .ctrl_q       (ctrl_q),
        .tc_q         (tc_q)
    );

    lcc_meas #(.WIN(WIN), .CNT_W(CNT_W)) u_meas (
        .clk       (clk),
        .rst       (rst),
        .run       (calibrating),
        .osc_tick  (osc_tick),
        .ref_tick  (ref_tick),
        .win_end   (win_end),
        .win_count (win_count)
    );

    lcc_divider #(.DIV(DIV)) u_div (
        .clk        (clk),
        .rst        (rst),
        .osc_tick   (osc_tick),
        .line_pulse (line_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_WAIT_XTAL;
            freq_code  <= SAFE_CODE;
            settle     <= 1'b1;
            meas_valid <= 1'b0;
            meas_count <= '0;
        end else begin
            meas_valid <= 1'b0;
            case (state)
                ST_WAIT_XTAL: if (wr_xtal) state <= ST_WAIT_START;
                ST_WAIT_START: if (wr_ctrl) begin
                    state     <= ST_CAL;
                    freq_code <= SAFE_CODE;
                    settle    <= 1'b1;
                end
                ST_CAL: if (win_end) begin
                    if (settle) begin
                        settle <= 1'b0;
                    end else begin
                        meas_valid <= 1'b1;
                        meas_count <= win_count;
                        if ((win_count > TGT_CNT) && (freq_code != '0)) begin
                            freq_code <= freq_code - CODE_W'(1);
                            settle    <= 1'b1;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: if (out_of_lock) begin
                    state     <= ST_CAL;
                    freq_code <= SAFE_CODE;
                    settle    <= 1'b1;
                end
                default: state <= ST_WAIT_XTAL;
            endcase
        end
    end

    assign calibrating = (state == ST_CAL);
    assign cal_done    = (state == ST_RUN);
    assign loop_open   = ctrl_q.open;
    assign tc_sel      = tc_q;

endmodule

// File: rtl/line_cal_ctrl_chk.sv
module line_cal_ctrl_chk #(
    parameter int unsigned CODE_W    = 8,
    parameter int unsigned CODE_SAFE = 200,
    parameter int unsigned TARGET    = 180,
    parameter int unsigned CNT_W     = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic [7:0]        wr_addr,
    input logic [2:0]        wr_data,
    input logic              out_of_lock,
    input logic [CODE_W-1:0] freq_code,
    input logic              line_pulse,
    input logic              calibrating,
    input logic              cal_done,
    input logic              meas_valid,
    input logic [CNT_W-1:0]  meas_count,
    input logic [1:0]        xtal_sel
);
    a_r2_safe_before_cal: assert property (@(posedge clk) disable iff (rst)
        (!calibrating && !cal_done) |-> (freq_code == CODE_W'(CODE_SAFE)));

    a_r3_xtal_store: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == 8'h00) |=> (xtal_sel == $past(wr_data[1:0])));

    a_r4_start_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(calibrating) |-> ($past(wr_stb && wr_addr == 8'h01) || $past(out_of_lock)));

    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && (meas_count > CNT_W'(TARGET)) && ($past(freq_code) != '0))
            |-> (freq_code == $past(freq_code) - CODE_W'(1)));

    a_r5_no_rise: assert property (@(posedge clk) disable iff (rst)
        (calibrating && $past(calibrating)) |-> (freq_code <= $past(freq_code)));

    a_r6_stop_at_target: assert property (@(posedge clk) disable iff (rst)
        $fell(calibrating) |-> (meas_valid && (meas_count <= CNT_W'(TARGET)) && cal_done));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(calibrating && cal_done));

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
        line_pulse |=> !line_pulse);

endmodule

bind line_cal_ctrl line_cal_ctrl_chk #(
    .CODE_W(CODE_W), .CODE_SAFE(CODE_SAFE), .TARGET(TARGET), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .out_of_lock (out_of_lock),
    .freq_code   (freq_code),
    .line_pulse  (line_pulse),
    .calibrating (calibrating),
    .cal_done    (cal_done),
    .meas_valid  (meas_valid),
    .meas_count  (meas_count),
    .xtal_sel    (xtal_sel)
);

// File: tb/line_cal_ctrl_tb_top.sv
`timescale 1ns/1ps
module line_cal_ctrl_tb_top;
    localparam int SAFE = 200;
    localparam int TGT  = 180;

    // {mode[1:0], locked, noisy, expected tc[1:0]}; tc slow=0 medium=1 fast=2
    localparam logic [5:0] TC_VEC [8] = '{
        6'b00_1_0_00, 6'b00_0_0_01, 6'b00_1_1_01, 6'b01_1_0_10,
        6'b01_0_1_10, 6'b10_0_1_00, 6'b11_1_0_00, 6'b11_0_1_01
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b0;
    logic        ref_tick = 1'b1;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [2:0]  wr_data = '0;
    logic        out_of_lock = 1'b0;
    logic        phase_locked = 1'b0;
    logic        noise_flag = 1'b0;
    logic [7:0]  freq_code;
    logic        line_pulse, calibrating, cal_done, meas_valid, loop_open;
    logic [15:0] meas_count;
    logic [1:0]  xtal_sel, tc_sel;

    int n_chk = 0;
    int n_fail = 0;
    int n_valid = 0;
    int exp_meas = SAFE;
    int last_meas = -1;
    int ticks_since = 0;
    int n_lines = 0;
    logic cal_prev = 1'b0;
    logic [7:0] nco_acc = '0;
    logic [8:0] nco_sum;

    always #10 clk = ~clk;

    line_cal_ctrl dut_i (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .ref_tick(ref_tick),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_of_lock(out_of_lock), .phase_locked(phase_locked), .noise_flag(noise_flag),
        .freq_code(freq_code), .line_pulse(line_pulse), .calibrating(calibrating),
        .cal_done(cal_done), .meas_valid(meas_valid), .meas_count(meas_count),
        .xtal_sel(xtal_sel), .loop_open(loop_open), .tc_sel(tc_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [2:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_cal_end();
        for (int k = 0; k < 40000 && calibrating; k++) @(negedge clk);
    endtask

    // Oscillator model: phase accumulator, ticks per 256 cycles equal the code
    assign nco_sum = {1'b0, nco_acc} + {1'b0, freq_code};
    initial forever begin
        @(posedge clk);
        nco_acc  <= nco_sum[7:0];
        osc_tick <= nco_sum[8];
    end

    // Monitors: window counts (R5) and line period (R9)
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (calibrating && !cal_prev) exp_meas = SAFE;
            cal_prev = calibrating;
            if (meas_valid) begin
                chk(meas_count == exp_meas, "R5 window count", meas_count, exp_meas);
                last_meas = meas_count;
                exp_meas--;
                n_valid++;
            end
            if (line_pulse) begin
                if (n_lines > 0) chk(ticks_since == 432, "R9 line period", ticks_since, 432);
                n_lines++;
                ticks_since = 0;
            end
            if (osc_tick) ticks_since++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int code_before;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(freq_code == SAFE, "R1 code", freq_code, SAFE);
        chk(!calibrating && !cal_done && !meas_valid && !line_pulse, "R1 flags",
            {calibrating, cal_done, meas_valid, line_pulse}, 0);
        chk(!loop_open && xtal_sel == 0, "R1 regs", {loop_open, xtal_sel}, 0);
        chk(tc_sel == 1, "R1 tc auto", tc_sel, 1);

        // R4: control write before crystal write is ignored
        wr(8'h01, 3'b000);
        repeat (700) @(negedge clk);
        chk(!calibrating, "R4 early start", calibrating, 0);
        chk(freq_code == SAFE && n_valid == 0, "R2 code held", freq_code, SAFE);

        // R3 crystal bits
        wr(8'h00, 3'b010);
        chk(xtal_sel == 2, "R3 xtal", xtal_sel, 2);
        chk(!calibrating, "R4 no start on xtal", calibrating, 0);

        // R4 start, R5/R6 convergence
        wr(8'h01, 3'b000);
        chk(calibrating, "R4 start", calibrating, 1);
        wait_cal_end();
        chk(freq_code == TGT, "R6 final code", freq_code, TGT);
        chk(cal_done && !calibrating, "R6 done", cal_done, 1);
        chk(n_valid == SAFE - TGT + 1, "R5 measurements", n_valid, SAFE - TGT + 1);
        chk(last_meas == TGT, "R6 last count", last_meas, TGT);

        // R8: control write while calibrated does not restart
        wr(8'h01, 3'b000);
        repeat (600) @(negedge clk);
        chk(!calibrating && freq_code == TGT, "R8 no restart", freq_code, TGT);

        // R7: loss of lock restarts from the safe code
        @(negedge clk); out_of_lock = 1'b1;
        @(negedge clk); out_of_lock = 1'b0;
        chk(calibrating, "R7 restart", calibrating, 1);
        chk(freq_code == SAFE, "R7 safe reload", freq_code, SAFE);
        repeat (3000) @(negedge clk);
        code_before = freq_code;
        @(negedge clk); out_of_lock = 1'b1;
        @(negedge clk); out_of_lock = 1'b0;
        chk(freq_code <= code_before && freq_code < SAFE, "R7 ignored in cal", freq_code, code_before);
        wait_cal_end();
        chk(freq_code == TGT && cal_done, "R7 reconverge", freq_code, TGT);
        chk(n_valid == 2 * (SAFE - TGT + 1), "R7 measurements", n_valid, 2 * (SAFE - TGT + 1));
        chk(n_lines > 10, "R9 pulses seen", n_lines, 11);

        // R10 loop open, R11 time constant table
        for (int i = 0; i < 8; i++) begin
            wr(8'h01, {TC_VEC[i][5:4], i[0]});
            phase_locked = TC_VEC[i][3];
            noise_flag   = TC_VEC[i][2];
            @(negedge clk);
            chk(tc_sel == TC_VEC[i][1:0], "R11 tc select", tc_sel, TC_VEC[i][1:0]);
            chk(loop_open == i[0], "R10 loop open", loop_open, i[0]);
            chk(!calibrating, "R8 ctrl write in run", calibrating, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule